// File: doc/BRIEF.md
# Receive Runt and Collision Frame Filter

This block sits on the receive path between the MAC byte stream and the write port of the receive FIFO. Each received byte is passed to the FIFO with one cycle of latency. When receive activity ends, the block decides whether the frame stays in the FIFO. A frame that is to be deleted, such as a runt or an early collision fragment, is removed by a single-cycle rewind pulse. The FIFO answers that pulse by moving its write pointer back to the position it saved when the frame started. A frame that stays gets a four-byte status record written directly after its data.

A collision stops all further FIFO writes for the frame, but the block keeps counting bytes until activity ends. The status therefore reports the full length of the activity, and it reports separately how many bytes were actually stored. In low-latency mode, runts are not deleted. Only collisions detected before a small threshold of stored bytes cause a discard. Successive frames must be separated by at least five idle cycles, so that the status append can finish before the next frame begins.

Top module: `rxflt_top`

## Requirements
- R1: Every byte taken with `rx_valid` high while `rx_active` is high is presented on `fifo_wr_data` with `fifo_wr_en` high in the following cycle, in arrival order, until a collision is seen.
- R2: In normal mode (`low_lat`=0), a frame whose total byte count is below 64 causes a single-cycle `fifo_rewind` pulse after activity ends, and no status record is written for it.
- R3: In normal mode, a frame that saw a collision with fewer than 64 bytes stored is discarded, even when activity continues to 64 or more bytes.
- R4: A byte that arrives in the cycle where `rx_coll` is first seen, and every byte after it in the same frame, is not written to the FIFO.
- R5: For a kept frame, four status bytes are written in consecutive cycles, starting two cycles after the cycle in which `rx_active` is first low. The bytes are: byte0 = count[7:0]; byte1 = {3'b000, collision flag in bit 4, count[11:8]}; byte2 = stored[7:0]; byte3 = {4'b0000, stored[11:8]}.
- R6: The count covers every valid byte of the activity, including bytes that arrive after a collision, and saturates at 4095. The stored count saturates in the same way.
- R7: `stat_count` and `stat_coll` take the values of a kept frame when its status append begins, and they hold across discarded frames.
- R8: In low-latency mode, a frame without a collision is kept whatever its length.
- R9: In low-latency mode, a collision with fewer than 12 bytes stored causes a discard. With 12 or more bytes stored, the truncated frame is kept.
- R10: `low_lat` is sampled in the cycle in which the end of activity is seen.
- R11: After reset, `fifo_wr_en`, `fifo_rewind`, `fifo_wr_data`, `stat_count` and `stat_coll` are all zero.
- R12: `fifo_rewind` and `fifo_wr_en` are never high in the same cycle, and `fifo_rewind` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | Receive activity (carrier) present |
| rx_valid | input | 1 | A byte is present on rx_byte |
| rx_byte | input | 8 | Received data byte |
| rx_coll | input | 1 | Collision detected |
| low_lat | input | 1 | Low-latency mode select |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 8 | FIFO write data |
| fifo_rewind | output | 1 | Rewind FIFO write pointer to frame start |
| stat_count | output | 12 | Byte count of the last kept frame |
| stat_coll | output | 1 | Collision flag of the last kept frame |

## Verification
The bench targets the exact boundaries of each mode: 63 against 64 bytes in normal mode, and 11 against 12 stored bytes before a low-latency collision. A design with an off-by-one compare would keep a runt or drop a valid frame. It also tests a normal-mode collision that arrives before the slot boundary but is followed by enough activity to pass 64 bytes. A design that judged frames by total count alone would keep that fragment. Further frames check that bytes stop being stored at the collision cycle while the reported count keeps growing, and that the count saturates on a very long frame. A design that froze the count at the collision, or that let it wrap, would produce wrong status bytes. Discarded frames between kept ones confirm that the status outputs are not overwritten by deleted frames.

// File: rtl/rxflt_pkg.sv
package rxflt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_APPEND = 2'd2
    } rxflt_state_e;
endpackage

// File: rtl/rxflt_sat_inc.sv
module rxflt_sat_inc #(
    parameter int W = 12
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    always_comb begin
        if (val_i == MAXV) val_o = MAXV;
        else               val_o = val_i + 1'b1;
    end
endmodule

// File: rtl/rxflt_decide.sv
module rxflt_decide #(
    parameter int CNT_W     = 12,
    parameter int MIN_LEN   = 64,
    parameter int LL_THRESH = 12
) (
    input  logic             low_lat_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [CNT_W-1:0] stored_i,
    input  logic             coll_i,
    output logic             discard_o
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] LL_V  = CNT_W'(LL_THRESH);
    always_comb begin
        if (low_lat_i) discard_o = coll_i && (stored_i < LL_V);
        else           discard_o = (total_i < MIN_V) || (coll_i && (stored_i < MIN_V));
    end
endmodule

// File: rtl/rxflt_status_fmt.sv
module rxflt_status_fmt #(
    parameter int CNT_W   = 12,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [CNT_W-1:0] stored_i,
    input  logic             coll_i,
    output logic [7:0]       byte_o
);
    logic [15:0] total_w, stored_w;
    always_comb begin
        total_w  = 16'(total_i);
        stored_w = 16'(stored_i);
        case (idx_i)
            2'd0:    byte_o = total_w[7:0];
            2'd1:    byte_o = {3'b000, coll_i, total_w[11:8]};
            2'd2:    byte_o = stored_w[7:0];
            default: byte_o = {4'b0000, stored_w[11:8]};
        endcase
    end
endmodule

// File: rtl/rxflt_top.sv
module rxflt_top #(
    parameter int CNT_W     = 12,
    parameter int MIN_LEN   = 64,
    parameter int LL_THRESH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_coll,
    input  logic             low_lat,
    output logic             fifo_wr_en,
    output logic [7:0]       fifo_wr_data,
    output logic             fifo_rewind,
    output logic [CNT_W-1:0] stat_count,
    output logic             stat_coll
);
    import rxflt_pkg::*;

    localparam int STAT_BYTES = 4;
    localparam int IDX_W      = $clog2(STAT_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STAT_BYTES - 1);

    typedef struct packed {
        rxflt_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wcnt;
        logic             coll;
        logic [IDX_W-1:0] idx;
        logic             wr_en;
        logic [7:0]       wr_data;
        logic             rewind;
        logic [CNT_W-1:0] stat_cnt;
        logic             stat_coll;
    } regs_t;

    regs_t q, d;

    logic             first_w;
    logic [CNT_W-1:0] cnt_base, wcnt_base, cnt_inc, wcnt_inc;
    logic             coll_now;
    logic             discard_w;
    logic [7:0]       stat_byte;

    always_comb begin
        first_w   = (q.st == ST_IDLE) && rx_active;
        cnt_base  = first_w ? '0 : q.cnt;
        wcnt_base = first_w ? '0 : q.wcnt;
        coll_now  = (first_w ? 1'b0 : q.coll) | rx_coll;
    end

    rxflt_sat_inc #(.W(CNT_W)) u_cnt_inc  (.val_i(cnt_base),  .val_o(cnt_inc));
    rxflt_sat_inc #(.W(CNT_W)) u_wcnt_inc (.val_i(wcnt_base), .val_o(wcnt_inc));

    rxflt_decide #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .LL_THRESH(LL_THRESH)) u_decide (
        .low_lat_i (low_lat),
        .total_i   (q.cnt),
        .stored_i  (q.wcnt),
        .coll_i    (q.coll),
        .discard_o (discard_w)
    );

    rxflt_status_fmt #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_fmt (
        .idx_i    (q.idx),
        .total_i  (q.cnt),
        .stored_i (q.wcnt),
        .coll_i   (q.coll),
        .byte_o   (stat_byte)
    );

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.wr_data = 8'h00;
        d.rewind  = 1'b0;
        case (q.st)
            ST_IDLE, ST_RECV: begin
                if (rx_active) begin
                    d.st   = ST_RECV;
                    d.cnt  = cnt_base;
                    d.wcnt = wcnt_base;
                    d.coll = coll_now;
                    if (rx_valid) begin
                        d.cnt = cnt_inc;
                        if (!coll_now) begin
                            d.wr_en   = 1'b1;
                            d.wr_data = rx_byte;
                            d.wcnt    = wcnt_inc;
                        end
                    end
                end else if (q.st == ST_RECV) begin
                    if (discard_w) begin
                        d.rewind = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        d.st        = ST_APPEND;
                        d.idx       = '0;
                        d.stat_cnt  = q.cnt;
                        d.stat_coll = q.coll;
                    end
                end
            end
            ST_APPEND: begin
                d.wr_en   = 1'b1;
                d.wr_data = stat_byte;
                d.idx     = q.idx + 1'b1;
                if (q.idx == IDX_LAST) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign fifo_wr_en   = q.wr_en;
    assign fifo_wr_data = q.wr_data;
    assign fifo_rewind  = q.rewind;
    assign stat_count   = q.stat_cnt;
    assign stat_coll    = q.stat_coll;

    logic             in_recv, in_append, coll_seen;
    logic [CNT_W-1:0] total_q;
    assign in_recv   = (q.st == ST_RECV);
    assign in_append = (q.st == ST_APPEND);
    assign coll_seen = q.coll;
    assign total_q   = q.cnt;

    // R12
    wr_rewind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_wr_en && fifo_rewind));

    // R12
    rewind_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rewind |=> !fifo_rewind);

    // R4
    coll_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && coll_seen) |=> !fifo_wr_en);

    // R5
    append_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_append |=> fifo_wr_en);

    // R7
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && rx_active) |=> $stable(stat_count) && $stable(stat_coll));

    // R2
    normal_discard_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recv && !rx_active && !low_lat && (total_q < CNT_W'(MIN_LEN))) |=> fifo_rewind);
endmodule

// File: tb/rxflt_top_test.sv
module rxflt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_active = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_coll = 1'b0;
    logic        low_lat = 1'b0;
    logic        fifo_wr_en;
    logic [7:0]  fifo_wr_data;
    logic        fifo_rewind;
    logic [11:0] stat_count;
    logic        stat_coll;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    byte unsigned fifo_q[$];
    byte unsigned exp_q[$];
    int frame_start = 0;
    int exp_stat_cnt = 0;
    bit exp_stat_coll = 1'b0;

    always #5 clk = ~clk;

    rxflt_top uut (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_coll(rx_coll), .low_lat(low_lat),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .fifo_rewind(fifo_rewind),
        .stat_count(stat_count), .stat_coll(stat_coll)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // FIFO model driven by the design outputs, sampled away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            // R12 every clock
            check(!(fifo_wr_en && fifo_rewind), "R12 write with rewind", int'(fifo_wr_en), 0);
            if (fifo_rewind) begin
                while (fifo_q.size() > frame_start) void'(fifo_q.pop_back());
            end
            if (fifo_wr_en) fifo_q.push_back(fifo_wr_data);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run_frame(input int len, input int coll_at, input bit ll, input string req);
        int stored;
        bit coll;
        bit keep;
        int c_cnt, c_st;
        coll   = (coll_at >= 0) && (coll_at < len);
        stored = coll ? coll_at : len;
        c_cnt  = (len > 4095) ? 4095 : len;
        c_st   = (stored > 4095) ? 4095 : stored;
        if (ll) keep = !(coll && stored < 12);
        else    keep = (len >= 64) && !(coll && stored < 64);
        @(negedge clk);
        frame_start = fifo_q.size();
        low_lat = ll;
        for (int i = 0; i < len; i++) begin
            rx_active = 1'b1;
            rx_valid  = 1'b1;
            rx_byte   = 8'((i * 7 + len) & 8'hFF);
            if (coll && i >= coll_at) rx_coll = 1'b1;
            @(negedge clk);
        end
        rx_active = 1'b0; rx_valid = 1'b0; rx_coll = 1'b0;
        if (keep) begin
            for (int i = 0; i < stored; i++) exp_q.push_back(8'((i * 7 + len) & 8'hFF));
            exp_q.push_back(8'(c_cnt & 8'hFF));
            exp_q.push_back(8'({3'b000, coll, 4'((c_cnt >> 8) & 4'hF)}));
            exp_q.push_back(8'(c_st & 8'hFF));
            exp_q.push_back(8'((c_st >> 8) & 8'h0F));
            exp_stat_cnt  = c_cnt;
            exp_stat_coll = coll;
        end
        repeat (8) @(negedge clk);
        begin
            bit same;
            same = (fifo_q.size() == exp_q.size());
            if (same) foreach (exp_q[k]) if (fifo_q[k] != exp_q[k]) same = 1'b0;
            check(same, req, fifo_q.size(), exp_q.size());
        end
        check(stat_count == 12'(exp_stat_cnt), {req, " R7 count"}, int'(stat_count), exp_stat_cnt);
        check(stat_coll == exp_stat_coll, {req, " R7 coll"}, int'(stat_coll), int'(exp_stat_coll));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(fifo_wr_en == 1'b0 && fifo_rewind == 1'b0 && fifo_wr_data == 8'h00,
              "R11 fifo outputs", int'(fifo_wr_en) + int'(fifo_rewind) + int'(fifo_wr_data), 0);
        check(stat_count == 12'h000 && stat_coll == 1'b0, "R11 status outputs", int'(stat_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(80, -1, 1'b0, "R1 R5 normal kept");
        run_frame(63, -1, 1'b0, "R2 normal runt 63");
        run_frame(64, -1, 1'b0, "R2 normal boundary 64");
        run_frame(70, 30, 1'b0, "R3 slot collision");
        run_frame(90, 66, 1'b0, "R4 R6 late collision");
        run_frame(5, -1, 1'b1, "R8 lowlat runt");
        run_frame(20, 11, 1'b1, "R9 lowlat coll 11");
        run_frame(20, 12, 1'b1, "R9 lowlat coll 12");
        run_frame(20, 0, 1'b1, "R4 coll first byte");
        run_frame(40, -1, 1'b1, "R10 lowlat 40");
        run_frame(40, -1, 1'b0, "R10 normal 40");
        run_frame(4100, -1, 1'b0, "R6 saturation");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule